// File: doc/BRIEF.md
# SPI Sensor Register Sequencer

After reset, this block loads an image sensor's start-up settings over SPI. It holds a fixed list of register writes. Each write is a 24-bit word made of a device-select byte, a register address and a value. The block sends the list one word at a time and waits for the serial engine to go idle before it sends the next word.

The list is framed by two mode writes. The first word puts the sensor into standby so that it does not stream while its registers change. The last word releases standby and starts free-running output. After the last word and a programmable settle time, the block raises a done flag. Software takes no part in this, and nothing can be read back.

The serial clock is the system clock divided by `CLK_DIV`, which is 16 by default. This keeps SCLK under the sensor's 28 MHz limit with margin.

Top module: `sensor_spi_seq`

## Requirements
- R1: While reset is held and right after it is released, `spi_cs_n` is 1, `spi_sclk` is 0 and `cfg_done` is 0.
- R2: Each list entry goes out as one 24-bit word in a single `spi_cs_n` low window, most significant bit first. The order is bits 23..16 device byte, 15..8 register address, 7..0 value.
- R3: The device byte of every word is 0x02.
- R4: The first word written after reset is address 0x00 with value 0x31, which selects standby.
- R5: The final word is address 0x00 with value 0x00, which releases standby and starts streaming. No word follows it.
- R6: The words in between appear in this order as (address, value) pairs: (0x01,0x01) vertical flip, (0x02,0x0F) 1080p mode, (0x03,0x4C) and (0x04,0x04) line length 1100 low then high, (0x05,0x65) and (0x06,0x04) frame length 1125 low then high, (0x11,0x00) output rate, (0x12,0x82) 12-bit conversion, (0x3B,0xE1) parallel sync codes. The list has 11 words in all.
- R7: SPI mode 0 is used. SCLK is low whenever `spi_cs_n` is high. Each SCLK period is exactly `CLK_DIV` system cycles, with a high phase of `CLK_DIV/2` cycles. MOSI is stable at every rising edge of SCLK.
- R8: Between two words, `spi_cs_n` stays high for at least `CLK_DIV` system cycles.
- R9: A new word starts only after the previous one has finished.
- R10: `cfg_done` rises no sooner than `SETTLE_CYCLES` system cycles after the final `spi_cs_n` rise, and within `SETTLE_CYCLES + CLK_DIV + 4` cycles of it. It then stays high until reset.
- R11: A reset in the middle of a word aborts the word. After release, the sequence restarts from the first word.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous reset, active low |
| spi_sclk | output | 1 | Serial clock, idle low |
| spi_mosi | output | 1 | Serial data to the sensor |
| spi_cs_n | output | 1 | Chip select, active low |
| cfg_done | output | 1 | High once the list is written and the settle time has passed |

## Verification
Corrupt internal state shows up at the pins within one word. A list index that is off by one sends the wrong address/value pair in the next chip-select window, and the scoreboard flags that word. A bit counter or divider that slips changes the number of SCLK edges in the window, or the SCLK period, within 16 system cycles. A sequencer that skips its idle wait shortens the chip-select gap or drops a word. A settle counter that is wrong moves `cfg_done` outside its window after the final chip-select rise.

// File: rtl/sensor_seq_pkg.sv
// Package: shared types and the sensor bring-up write list.
// Assumes: every entry targets device byte 0x02; the list starts and ends with mode writes.
package sensor_seq_pkg;

    typedef struct packed {
        logic [7:0] dev;
        logic [7:0] addr;
        logic [7:0] val;
    } wr_entry_t;

    localparam int          NUM_ENTRIES = 11;
    localparam logic [7:0]  DEV_SEL     = 8'h02;
    localparam logic [7:0]  MODE_REG    = 8'h00;
    localparam logic [7:0]  MODE_STBY   = 8'h31;
    localparam logic [7:0]  MODE_RUN    = 8'h00;

    typedef enum logic [1:0] {TX_IDLE, TX_SHIFT, TX_GAP} tx_state_t;
    typedef enum logic [1:0] {SQ_ISSUE, SQ_WAIT, SQ_SETTLE, SQ_DONE} sq_state_t;

    // Returns list entry idx; the first and last entries set the operating mode.
    function automatic wr_entry_t list_entry(input int idx);
        logic [15:0] av;
        case (idx)
            0:       av = {MODE_REG, MODE_STBY};
            1:       av = 16'h01_01;  // vertical flip
            2:       av = 16'h02_0F;  // 1080p
            3:       av = 16'h03_4C;  // line length low  (1100)
            4:       av = 16'h04_04;  // line length high
            5:       av = 16'h05_65;  // frame length low (1125)
            6:       av = 16'h06_04;  // frame length high
            7:       av = 16'h11_00;  // output rate
            8:       av = 16'h12_82;  // 12-bit conversion
            9:       av = 16'h3B_E1;  // parallel sync codes
            default: av = {MODE_REG, MODE_RUN};
        endcase
        return '{dev: DEV_SEL, addr: av[15:8], val: av[7:0]};
    endfunction

endpackage

// File: rtl/sensor_wr_list.sv
// Module: combinational lookup of the write list by index.
// Assumes: idx_i never exceeds NUM_ENTRIES-1 (the sequencer saturates it).
module sensor_wr_list
    import sensor_seq_pkg::*;
#(
    parameter int IDX_W = $clog2(NUM_ENTRIES)
) (
    input  logic [IDX_W-1:0] idx_i,
    output wr_entry_t        entry_o
);
    // Map the index to the stored entry.
    always_comb entry_o = list_entry(int'(idx_i));
endmodule

// File: rtl/spi_word_tx.sv
// Module: SPI mode-0 transmitter for one word. CS_n goes low for the whole word,
// data leaves MSB first, and CS_n then stays high for CLK_DIV cycles before the next word can start.
// Assumes: CLK_DIV is even and at least 2; start_i is pulsed only while busy_o is low.
module spi_word_tx
    import sensor_seq_pkg::*;
#(
    parameter int CLK_DIV   = 16,
    parameter int WORD_BITS = 24
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 start_i,
    input  logic [WORD_BITS-1:0] word_i,
    output logic                 busy_o,
    output logic                 sclk_o,
    output logic                 mosi_o,
    output logic                 cs_n_o
);
    localparam int HALF = CLK_DIV / 2;
    localparam int DW   = $clog2(CLK_DIV);
    localparam int BW   = $clog2(WORD_BITS);

    tx_state_t            st;
    logic [DW-1:0]        div_cnt;
    logic [BW-1:0]        bit_cnt;
    logic [WORD_BITS-1:0] shreg;
    logic                 cs_n_q;

    // Word framing, bit shifting and the inter-word chip-select gap.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st      <= TX_IDLE;
            div_cnt <= '0;
            bit_cnt <= '0;
            shreg   <= '0;
            cs_n_q  <= 1'b1;
        end else begin
            case (st)
                TX_IDLE: if (start_i) begin
                    shreg   <= word_i;
                    cs_n_q  <= 1'b0;
                    div_cnt <= '0;
                    bit_cnt <= '0;
                    st      <= TX_SHIFT;
                end
                TX_SHIFT: if (div_cnt == DW'(CLK_DIV - 1)) begin
                    div_cnt <= '0;
                    if (bit_cnt == BW'(WORD_BITS - 1)) begin
                        cs_n_q <= 1'b1;
                        st     <= TX_GAP;
                    end else begin
                        bit_cnt <= bit_cnt + 1'b1;
                        shreg   <= {shreg[WORD_BITS-2:0], 1'b0};
                    end
                end else begin
                    div_cnt <= div_cnt + 1'b1;
                end
                TX_GAP: if (div_cnt == DW'(CLK_DIV - 1)) begin
                    div_cnt <= '0;
                    st      <= TX_IDLE;
                end else begin
                    div_cnt <= div_cnt + 1'b1;
                end
                default: st <= TX_IDLE;
            endcase
        end
    end

    // Output decode: SCLK is high in the second half of each bit period.
    always_comb begin
        busy_o = (st != TX_IDLE);
        sclk_o = (st == TX_SHIFT) && (div_cnt >= DW'(HALF));
        mosi_o = shreg[WORD_BITS-1];
        cs_n_o = cs_n_q;
    end

    assert_sclk_idle_R7: assert property (@(posedge clk) disable iff (!rst_n)
        cs_n_q |-> !sclk_o);
    assert_gap_cs_high_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (st == TX_GAP) |-> cs_n_q);
    assert_full_word_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (st == TX_SHIFT && cs_n_q == 1'b0) |=> (cs_n_q == 1'b0 || $past(bit_cnt) == BW'(WORD_BITS - 1)));
    assert_start_when_idle_R9: assert property (@(posedge clk) disable iff (!rst_n)
        start_i |-> (st == TX_IDLE));
endmodule

// File: rtl/settle_timer.sv
// Module: counts system cycles while run_i is high and flags expiry after CYCLES of them.
// Assumes: run_i stays high once raised until reset; the count saturates at CYCLES.
module settle_timer #(
    parameter int CYCLES = 200
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run_i,
    output logic expired_o
);
    localparam int CW = $clog2(CYCLES + 1);
    logic [CW-1:0] cnt;

    // Count up while running, stop at the limit.
    always_ff @(posedge clk) begin
        if (!rst_n)                              cnt <= '0;
        else if (run_i && cnt != CW'(CYCLES))    cnt <= cnt + 1'b1;
    end

    // Expiry decode.
    always_comb expired_o = (cnt == CW'(CYCLES));
endmodule

// File: rtl/sensor_spi_seq.sv
// Module (top): after reset, sends every entry of the sensor write list over SPI in order,
// waiting for each word to finish, then waits SETTLE_CYCLES and holds cfg_done high until reset.
// Assumes: the SCLK limit is met by choosing CLK_DIV for the system clock (default 16).
module sensor_spi_seq
    import sensor_seq_pkg::*;
#(
    parameter int CLK_DIV       = 16,
    parameter int SETTLE_CYCLES = 200
) (
    input  logic clk,
    input  logic rst_n,
    output logic spi_sclk,
    output logic spi_mosi,
    output logic spi_cs_n,
    output logic cfg_done
);
    localparam int IDX_W = $clog2(NUM_ENTRIES);
    localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(NUM_ENTRIES - 1);

    sq_state_t         st;
    logic [IDX_W-1:0]  idx;
    wr_entry_t         entry;
    logic              tx_start, tx_busy, settle_run, settle_exp;

    sensor_wr_list #(.IDX_W(IDX_W)) u_list (.idx_i(idx), .entry_o(entry));

    spi_word_tx #(.CLK_DIV(CLK_DIV), .WORD_BITS(24)) u_tx (
        .clk(clk), .rst_n(rst_n), .start_i(tx_start), .word_i(entry),
        .busy_o(tx_busy), .sclk_o(spi_sclk), .mosi_o(spi_mosi), .cs_n_o(spi_cs_n));

    settle_timer #(.CYCLES(SETTLE_CYCLES)) u_settle (
        .clk(clk), .rst_n(rst_n), .run_i(settle_run), .expired_o(settle_exp));

    // Walk the list: issue a word, wait for idle, advance or move on to settling.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st  <= SQ_ISSUE;
            idx <= '0;
        end else begin
            case (st)
                SQ_ISSUE:  st <= SQ_WAIT;
                SQ_WAIT:   if (!tx_busy) begin
                    if (idx == LAST_IDX) st <= SQ_SETTLE;
                    else begin
                        idx <= idx + 1'b1;
                        st  <= SQ_ISSUE;
                    end
                end
                SQ_SETTLE: if (settle_exp) st <= SQ_DONE;
                default:   st <= SQ_DONE;
            endcase
        end
    end

    // Control decode.
    always_comb begin
        tx_start   = (st == SQ_ISSUE);
        settle_run = (st == SQ_SETTLE);
        cfg_done   = (st == SQ_DONE);
    end

    assert_done_sticky_R10: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_done |=> cfg_done);
    assert_done_after_last_R5: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_done |-> (idx == LAST_IDX && !tx_busy));
    assert_first_standby_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_start && idx == '0) |-> (entry.addr == MODE_REG && entry.val == MODE_STBY));
    assert_last_release_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_start && idx == LAST_IDX) |-> (entry.addr == MODE_REG && entry.val == MODE_RUN));
    assert_device_byte_R3: assert property (@(posedge clk) disable iff (!rst_n)
        tx_start |-> (entry.dev == DEV_SEL));
endmodule

// File: tb/tb_sensor_spi_seq.sv
// Scoreboard bench: a driver task queues the expected words, and a negedge monitor
// rebuilds each SPI word and checks it against the queue along with the timing rules.
module tb_sensor_spi_seq;
    localparam int CLK_DIV = 16;
    localparam int SETTLE  = 200;
    localparam int NWORDS  = 11;

    logic clk = 1'b0, rst_n = 1'b0;
    logic spi_sclk, spi_mosi, spi_cs_n, cfg_done;

    sensor_spi_seq #(.CLK_DIV(CLK_DIV), .SETTLE_CYCLES(SETTLE)) dut (
        .clk(clk), .rst_n(rst_n), .spi_sclk(spi_sclk), .spi_mosi(spi_mosi),
        .spi_cs_n(spi_cs_n), .cfg_done(cfg_done));

    always #2 clk = ~clk;

    int checks = 0, fails = 0;
    int cyc = 0;
    logic [23:0] expq[$];
    int words_seen = 0;

    task automatic chk(input bit ok, input string req, input longint act, input longint exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // Expected word i of the list, taken from R3..R6.
    function automatic logic [23:0] exp_word(input int i);
        logic [15:0] p;
        case (i)
            0: p = 16'h0031;  1: p = 16'h0101;  2: p = 16'h020F;  3: p = 16'h034C;
            4: p = 16'h0404;  5: p = 16'h0565;  6: p = 16'h0604;  7: p = 16'h1100;
            8: p = 16'h1282;  9: p = 16'h3BE1;  default: p = 16'h0000;
        endcase
        return {8'h02, p};
    endfunction

    task automatic push_all();
        expq.delete();
        for (int i = 0; i < NWORDS; i++) expq.push_back(exp_word(i));
    endtask

    always @(posedge clk) cyc <= cyc + 1;

    // Monitor: rebuild the words, check the timing and pop from the scoreboard.
    logic        sclk_p = 1'b0, cs_p = 1'b1;
    logic [23:0] acc;
    int          nbits = 0, last_rise = -1, last_cs_rise = -1, sclk_rise_t = -1;
    bit          seen_done = 1'b0;
    always @(negedge clk) begin
        if (!rst_n) begin
            nbits = 0; acc = '0; last_cs_rise = -1; sclk_rise_t = -1;
            words_seen = 0; seen_done = 1'b0;
        end else begin
            if (spi_cs_n && spi_sclk) chk(0, "R7 sclk high with cs_n high", 1, 0);
            if (spi_sclk && !sclk_p && !spi_cs_n) begin
                if (sclk_rise_t >= 0 && nbits > 0)
                    chk(cyc - sclk_rise_t == CLK_DIV, "R7 sclk period", cyc - sclk_rise_t, CLK_DIV);
                sclk_rise_t = cyc;
                acc = {acc[22:0], spi_mosi};
                nbits++;
            end
            if (!spi_sclk && sclk_p && !spi_cs_n)
                chk(cyc - sclk_rise_t == CLK_DIV/2, "R7 sclk high phase", cyc - sclk_rise_t, CLK_DIV/2);
            if (!spi_cs_n && cs_p) begin
                if (last_cs_rise >= 0)
                    chk(cyc - last_cs_rise >= CLK_DIV, "R8 cs_n gap", cyc - last_cs_rise, CLK_DIV);
                chk(!seen_done, "R5 word after done", 1, 0);
                nbits = 0; sclk_rise_t = -1;
            end
            if (spi_cs_n && !cs_p) begin
                last_cs_rise = cyc;
                chk(nbits == 24, "R2 bits per word", nbits, 24);
                if (expq.size() == 0) chk(0, "R9 unexpected extra word", acc, 0);
                else begin
                    logic [23:0] e;
                    e = expq.pop_front();
                    chk(acc[23:16] == 8'h02, "R3 device byte", acc[23:16], 8'h02);
                    chk(acc == e, (words_seen == 0) ? "R4 first word" :
                        (words_seen == NWORDS-1) ? "R5 last word" : "R6 word order", acc, e);
                end
                words_seen++;
            end
            if (cfg_done && !seen_done) begin
                seen_done = 1'b1;
                chk(last_cs_rise >= 0 && cyc - last_cs_rise >= SETTLE, "R10 done too early", cyc - last_cs_rise, SETTLE);
                chk(cyc - last_cs_rise <= SETTLE + CLK_DIV + 4, "R10 done too late", cyc - last_cs_rise, SETTLE + CLK_DIV + 4);
            end
            if (seen_done) begin
                if (!cfg_done) chk(0, "R10 done dropped", 0, 1);
            end
        end
        sclk_p = spi_sclk; cs_p = spi_cs_n;
    end

    task automatic wait_done();
        while (!cfg_done) @(negedge clk);
        repeat (50) @(negedge clk);
        chk(cfg_done, "R10 done held", cfg_done, 1);
        chk(words_seen == NWORDS, "R6 word count", words_seen, NWORDS);
        chk(expq.size() == 0, "R9 scoreboard drained", expq.size(), 0);
    endtask

    // Watchdog.
    initial begin
        repeat (100000) @(posedge clk);
        chk(0, "watchdog", 0, 1);
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    // Driver.
    initial begin
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        chk(spi_cs_n && !spi_sclk && !cfg_done, "R1 state in reset", {spi_cs_n, spi_sclk, cfg_done}, 3'b100);
        push_all();
        rst_n = 1'b1;
        @(negedge clk);
        chk(!cfg_done && !spi_sclk, "R1 state after release", {spi_sclk, cfg_done}, 0);
        wait_done();

        // R11: restart after a reset in the middle of a word.
        rst_n = 1'b0; @(negedge clk);
        chk(!cfg_done && spi_cs_n, "R1 done cleared by reset", {cfg_done, spi_cs_n}, 2'b01);
        push_all();
        rst_n = 1'b1;
        while (words_seen < 2) @(negedge clk);
        while (spi_cs_n) @(negedge clk);
        repeat (5 * CLK_DIV) @(negedge clk);
        rst_n = 1'b0;
        repeat (2) @(negedge clk);
        chk(spi_cs_n && !spi_sclk, "R11 word aborted by reset", {spi_cs_n, spi_sclk}, 2'b10);
        push_all();
        rst_n = 1'b1;
        wait_done();
        chk(1, "R11 restart from first word", 0, 0);

        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end
endmodule